// File: doc/BRIEF.md
# Selectable Prescaler with Phase-Detector Glue

This block sits between two conditioned square waves and a microcontroller's timer-capture input. One input is the measurement signal coming out of a comparator; the other is a reference square wave from a frequency synthesizer. The block combines the two into a phase-detector output. It passes the reference onto an auxiliary pin only while an enable input is high. It also feeds the timer input with the measurement signal divided by 1, 16, 256 or 4096.

The logic runs on one system clock that is faster than the measurement signal. The measurement input is registered once. Each rising edge seen on that registered copy becomes a one-cycle event pulse. The divider is a chain of identical stages. Each stage counts the events from the stage before it and toggles a square-wave flip-flop every eighth event, so each stage divides by 16 with a 50% duty cycle. A stage's own event pulse is the cycle in which its square wave goes high. The ratio select picks either the registered input or one of the stage outputs. All divided taps change on the same clock edge, so switching the select never disturbs the counting.

Top module: `prescaler_glue`

## Requirements
- R1: `pd_out` equals `meas_in` XOR `ref_in` at all times (combinational).
- R2: `aux_out` equals `ref_in` while `aux_en` is 1, and is driven 0 while `aux_en` is 0.
- R3: With `sel` = 00, `tmr_out` equals the value `meas_in` had at the previous rising clock edge (divide by 1).
- R4: With `sel` = 01, `tmr_out` is a square wave of period 16 measurement cycles, high for 8 of them. Its first rise comes on the 8th measurement rising edge after reset.
- R5: With `sel` = 10, `tmr_out` has a period of 256 measurement cycles and a 50% duty cycle.
- R6: With `sel` = 11, `tmr_out` has a period of 4096 measurement cycles and a 50% duty cycle.
- R7: A synchronous active-high `rst` clears every counter, the input register and every square-wave flip-flop. After it, `tmr_out` is 0 for every `sel`.
- R8: A stage output changes only in the cycle after an event from the previous stage. A rise in any divided output coincides with a rise in the registered input.
- R9: Changing `sel` at any time switches `tmr_out` to the newly selected tap at once. It does not reset or skip any stage count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| meas_in | input | 1 | Measurement square wave, synchronous to clk |
| ref_in | input | 1 | Reference square wave from the synthesizer |
| aux_en | input | 1 | Enable for the auxiliary reference output |
| sel | input | SEL_W (2) | Ratio select: 00 /1, 01 /16, 10 /256, 11 /4096 |
| pd_out | output | 1 | Phase-detector output (XOR of the two inputs) |
| aux_out | output | 1 | Gated reference output |
| tmr_out | output | 1 | Divided measurement signal to the timer |

## Verification
The assertions assume that `meas_in`, `ref_in`, `aux_en` and `sel` are synchronous to `clk` and stable around its rising edge. They also assume that `rst` is high at time zero, so every history they look at begins in the reset state. The stimulus changes all inputs only on the falling clock edge. It holds the measurement signal high and low for whole numbers of clock cycles in several duty patterns, down to one cycle each. The select is changed only between edges, so a switch lands in one defined cycle.

// File: rtl/prescaler_pkg.sv
package prescaler_pkg;

  // Division ratio contributed by one stage: wrap every 2**cnt_w events, toggle on wrap.
  function automatic int stage_ratio(input int cnt_w);
    return 1 << (cnt_w + 1);
  endfunction

  // Overall ratio seen on tap index k.
  function automatic int tap_ratio(input int cnt_w, input int k);
    int r;
    r = 1;
    for (int i = 0; i < k; i++) r = r * stage_ratio(cnt_w);
    return r;
  endfunction

endpackage

// File: rtl/prescale_stage.sv
module prescale_stage #(
  parameter int CNT_W = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic evt_in,
  output logic sq_out,
  output logic evt_out
);

  logic [CNT_W-1:0] cnt;
  logic             wrap;

  // Overflow: the last event of a full count.
  assign wrap    = evt_in && (cnt == {CNT_W{1'b1}});
  // A rising square wave is this stage's event for the next stage.
  assign evt_out = wrap && !sq_out;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      sq_out <= 1'b0;
    end else begin
      if (evt_in) cnt <= cnt + 1'b1;
      if (wrap)   sq_out <= ~sq_out;
    end
  end

endmodule

// File: rtl/ratio_mux.sv
module ratio_mux #(
  parameter int N     = 4,
  parameter int SEL_W = 2
) (
  input  logic [N-1:0]     taps,
  input  logic [SEL_W-1:0] sel,
  output logic             y
);

  always_comb begin
    y = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (sel == SEL_W'(i)) y = taps[i];
    end
  end

endmodule

// File: rtl/ref_glue.sv
module ref_glue (
  input  logic meas_in,
  input  logic ref_in,
  input  logic aux_en,
  output logic pd_out,
  output logic aux_out
);

  assign pd_out  = meas_in ^ ref_in;
  assign aux_out = aux_en & ref_in;

endmodule

// File: rtl/prescaler_glue.sv
module prescaler_glue #(
  parameter int STAGES = 3,
  parameter int CNT_W  = 3,
  parameter int SEL_W  = $clog2(STAGES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             meas_in,
  input  logic             ref_in,
  input  logic             aux_en,
  input  logic [SEL_W-1:0] sel,
  output logic             pd_out,
  output logic             aux_out,
  output logic             tmr_out
);

  localparam int TAPS = STAGES + 1;

  // evt[k]: one-cycle pulse on a rise of taps[k]; taps[k]: square wave at ratio 16**k.
  logic [STAGES:0] evt;
  logic [STAGES:0] taps;
  logic            meas_q;

  always_ff @(posedge clk) begin
    if (rst) meas_q <= 1'b0;
    else     meas_q <= meas_in;
  end

  assign evt[0]  = meas_in && !meas_q;
  assign taps[0] = meas_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    prescale_stage #(.CNT_W(CNT_W)) u_stage (
      .clk    (clk),
      .rst    (rst),
      .evt_in (evt[g]),
      .sq_out (taps[g+1]),
      .evt_out(evt[g+1])
    );
  end

  ratio_mux #(.N(TAPS), .SEL_W(SEL_W)) u_mux (
    .taps(taps),
    .sel (sel),
    .y   (tmr_out)
  );

  ref_glue u_glue (
    .meas_in(meas_in),
    .ref_in (ref_in),
    .aux_en (aux_en),
    .pd_out (pd_out),
    .aux_out(aux_out)
  );

endmodule

// File: rtl/prescaler_glue_chk.sv
module prescaler_glue_chk #(
  parameter int STAGES = 3,
  parameter int SEL_W  = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             meas_in,
  input logic             ref_in,
  input logic             aux_en,
  input logic [SEL_W-1:0] sel,
  input logic             pd_out,
  input logic             aux_out,
  input logic             tmr_out,
  input logic [STAGES:0]  evt,
  input logic [STAGES:0]  taps
);

  // R1
  pd_low_ref_chk: assert property (@(posedge clk) disable iff (rst)
    !ref_in |-> (pd_out == meas_in));
  // R1
  pd_high_ref_chk: assert property (@(posedge clk) disable iff (rst)
    ref_in |-> (pd_out == !meas_in));
  // R2
  aux_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !aux_en |-> !aux_out);
  // R3
  bypass_chk: assert property (@(posedge clk) disable iff (rst)
    (sel == '0 && !$past(rst)) |-> (tmr_out == $past(meas_in)));
  // R7
  rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (taps == '0));

  for (genvar k = 0; k < STAGES; k++) begin : g_stage_chk
    // R8
    stage_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !evt[k] |=> (taps[k+1] == $past(taps[k+1])));
    // R8
    evt_chain_chk: assert property (@(posedge clk) disable iff (rst)
      evt[k+1] |-> evt[k]);
    // R4
    rise_align_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(taps[k+1]) |-> $rose(taps[0]));
  end

endmodule

bind prescaler_glue prescaler_glue_chk #(.STAGES(STAGES), .SEL_W(SEL_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .meas_in(meas_in),
  .ref_in (ref_in),
  .aux_en (aux_en),
  .sel    (sel),
  .pd_out (pd_out),
  .aux_out(aux_out),
  .tmr_out(tmr_out),
  .evt    (evt),
  .taps   (taps)
);

// File: tb/prescaler_glue_tb.sv
module prescaler_glue_tb;

  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       meas_in = 1'b0;
  logic       ref_in = 1'b0;
  logic       aux_en = 1'b0;
  logic [1:0] sel = 2'b00;
  logic       pd_out, aux_out, tmr_out;

  int errs = 0;
  int checks = 0;
  bit done = 0;

  // Behavioural reference: count of measurement rising edges since reset.
  int n = 0;
  bit mq = 0;
  bit prev_tmr = 0;
  int rises = 0;

  always #(CLK_P/2) clk = ~clk;

  prescaler_glue u_dut (
    .clk(clk), .rst(rst), .meas_in(meas_in), .ref_in(ref_in), .aux_en(aux_en),
    .sel(sel), .pd_out(pd_out), .aux_out(aux_out), .tmr_out(tmr_out)
  );

  function automatic bit expect_tmr(input int cnt, input bit q, input logic [1:0] s);
    int r1, r2;
    r1 = (cnt + 8) / 16;
    r2 = (r1 + 8) / 16;
    case (s)
      2'd0:    return q;
      2'd1:    return ((cnt / 8) % 2) == 1;
      2'd2:    return ((r1 / 8) % 2) == 1;
      default: return ((r2 / 8) % 2) == 1;
    endcase
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_int(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic string sel_tag(input logic [1:0] s);
    case (s)
      2'd0:    return "R3";
      2'd1:    return "R4";
      2'd2:    return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic step();
    @(posedge clk);
    if (rst) begin
      n = 0;
      mq = 0;
    end else begin
      if (meas_in && !mq) n++;
      mq = meas_in;
    end
    @(negedge clk);
    check(rst ? "R7" : sel_tag(sel), tmr_out, expect_tmr(n, mq, sel));
    if (tmr_out && !prev_tmr) rises++;
    prev_tmr = tmr_out;
  endtask

  task automatic run_cycles(input int cycles, input int hi, input int lo);
    for (int c = 0; c < cycles; c++) begin
      meas_in = 1'b1;
      repeat (hi) step();
      meas_in = 1'b0;
      repeat (lo) step();
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    meas_in = 1'b0;
    repeat (2) step();
    rst = 1'b0;
    rises = 0;
  endtask

  initial begin
    #(CLK_P * 190000);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    repeat (3) step();
    // R7: reset state
    check("R7", tmr_out, 1'b0);
    check("R2", aux_out, 1'b0);
    rst = 1'b0;

    // R1 and R2: every combination of the combinational inputs
    for (int v = 0; v < 8; v++) begin
      meas_in = v[0];
      ref_in  = v[1];
      aux_en  = v[2];
      #1;
      check("R1", pd_out, v[0] ^ v[1]);
      check("R2", aux_out, v[2] & v[1]);
      step();
    end
    ref_in = 1'b0;

    // R4: divide by 16, 64 cycles of 2 high / 2 low
    sel = 2'b01;
    do_reset();
    run_cycles(64, 2, 2);
    check_int("R4 period count", rises, 4);

    // R5: divide by 256, 512 cycles of 1 high / 3 low
    sel = 2'b10;
    do_reset();
    run_cycles(512, 1, 3);
    check_int("R5 period count", rises, 2);

    // R6: divide by 4096, 8192 cycles of 1 high / 1 low
    sel = 2'b11;
    do_reset();
    run_cycles(8192, 1, 1);
    check_int("R6 period count", rises, 2);

    // R3: bypass with irregular input
    sel = 2'b00;
    run_cycles(20, 3, 1);
    run_cycles(20, 1, 2);

    // R9: select changes mid-run without disturbing counts
    for (int k = 0; k < 40; k++) begin
      sel = 2'(k % 4);
      #1;
      check("R9", tmr_out, expect_tmr(n, mq, sel));
      run_cycles(7, 2, 1);
    end

    // R7: reset mid-run with the /16 tap high
    sel = 2'b01;
    do_reset();
    run_cycles(10, 1, 1);
    check("R4", tmr_out, 1'b1);
    rst = 1'b1;
    step();
    rst = 1'b0;
    for (int s = 0; s < 4; s++) begin
      sel = 2'(s);
      #1;
      check("R7", tmr_out, 1'b0);
    end
    sel = 2'b01;
    run_cycles(16, 2, 2);

    // R2: reference gated while enabled
    aux_en = 1'b1;
    ref_in = 1'b1;
    #1;
    check("R2", aux_out, 1'b1);
    aux_en = 1'b0;
    #1;
    check("R2", aux_out, 1'b0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule